// File: doc/BRIEF.md
# Endpoint-Zero Control Stage Sequencer

This block follows a control transfer on endpoint zero of a full-speed USB device through its stages. It watches the strobes the endpoint logic raises for OUT and IN activity. With each OUT strobe it reads three status bits: transfer complete, setup done and status phase received. It also reads a flag that says whether the most recently filled receive buffer holds a SETUP packet. The three status bits are folded into a case code. The case code, the flag and the current stage decide what the endpoint is told to do next.

The commands are single-cycle pulses:

- hand a SETUP packet to the request decoder;
- re-arm the OUT side for a fresh SETUP;
- stall both directions;
- enable the IN or OUT side, with or without clearing NAK.

When a SETUP is handed over, the request decoder answers in the same strobe cycle. It says whether the request is rejected and whether the request has an IN data stage. The block also rotates the indices of two one-packet receive buffers, so the packet just received is kept while the next one is being filled.

Top module: `ep0_stage_seq`

## Requirements
- R1: The case code is transfer-complete + 2×setup-done + 4×status-received. Code 1 is case A, 2 is B, 3 is C, 4 is D and 5 is E. Codes 0, 6 and 7 are invalid. Codes 0, 4, 5, 6 and 7 cause no command in the waiting stage.
- R2: In the waiting stage, an event with case A or C and the setup flag set pulses `dispatch`.
- R3: In the waiting stage, case A or C with the flag clear re-arms. Re-arming pulses `rearm`, `out_en` and `out_cnak`, and the block stays in or returns to the waiting stage.
- R4: In the waiting stage, case B pulses `stall_both` again, and the block stays waiting.
- R5: A rejected dispatch also pulses `stall_both` and returns to waiting. An accepted dispatch pulses `in_en` and `out_en`. It then moves to the IN data stage when `req_data_in` is 1, and to the no-data stage when it is 0. `stage` encodes waiting as 0, IN data as 1 and no-data as 2. Both clear-NAK outputs go with an accepted dispatch only when the triggering case was C.
- R6: In the IN data stage, the OUT status bits have no effect unless `out_irq` is high. An IN strobe with `in_xfer_done` only pulses `in_en`, without clear-NAK, and keeps the stage.
- R7: In the IN data stage, an OUT event of case B pulses all four enable and clear-NAK outputs and keeps the stage.
- R8: In the IN data stage, an OUT event of case A or C with the flag set dispatches, as an early SETUP. With the flag clear it re-arms. Other codes do nothing.
- R9: In the no-data stage, an OUT event of case B pulses all four enables. Case A or C with the flag set dispatches. Any other OUT event re-arms and returns to waiting. An IN completion pulses `in_en`.
- R10: On every OUT strobe with transfer complete, `cur_idx` takes the old `nxt_idx`, and `nxt_idx` advances modulo the buffer count. Otherwise both indices hold.
- R11: `rst` and `bus_rst` each force the waiting stage, both indices to 0 and all commands to 0. A strobe that arrives together with `bus_rst` is ignored.
- R12: Every command appears in the cycle after the strobe and lasts one cycle. With no strobe, no command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst | input | 1 | USB bus reset seen, synchronous |
| out_irq | input | 1 | OUT endpoint-zero interrupt strobe |
| in_irq | input | 1 | IN endpoint-zero interrupt strobe |
| out_xfer_done | input | 1 | OUT transfer-complete status bit |
| out_setup_done | input | 1 | OUT setup-done status bit |
| out_status_rcvd | input | 1 | OUT status-phase-received status bit |
| setup_flag | input | 1 | Latest completed OUT buffer holds a SETUP |
| in_xfer_done | input | 1 | IN transfer-complete status bit |
| req_reject | input | 1 | Decoder rejects the request (valid with the strobe) |
| req_data_in | input | 1 | Request has an IN data stage (valid with the strobe) |
| stage | output | 2 | Current stage: 0 waiting, 1 IN data, 2 no-data |
| cur_idx | output | IDX_W | Buffer holding the latest received packet |
| nxt_idx | output | IDX_W | Buffer the next packet is written to |
| dispatch | output | 1 | Hand the SETUP packet to the decoder |
| rearm | output | 1 | Re-arm for a new SETUP |
| stall_both | output | 1 | Stall IN and OUT |
| in_en | output | 1 | Enable IN endpoint |
| in_cnak | output | 1 | Clear NAK on IN |
| out_en | output | 1 | Enable OUT endpoint |
| out_cnak | output | 1 | Clear NAK on OUT |

## Verification
Every command pulse, the new stage and the new buffer indices are registered once. They are therefore due exactly one rising edge after the strobe cycle. The bench drives a strobe for one cycle on a falling edge and samples on the next falling edge, which lies just past that single register stage. It then samples again one falling edge later to confirm that the pulses have dropped. For the bus-reset case, the strobe and `bus_rst` share one cycle, and the outputs are read on the following falling edge.

// File: rtl/ep0_seq_pkg.sv
package ep0_seq_pkg;

  typedef enum logic [1:0] {
    STG_WAIT    = 2'd0,
    STG_DATA_IN = 2'd1,
    STG_NO_DATA = 2'd2
  } stage_e;

  typedef enum logic [2:0] {
    CC_BAD0 = 3'd0,
    CC_A    = 3'd1,
    CC_B    = 3'd2,
    CC_C    = 3'd3,
    CC_D    = 3'd4,
    CC_E    = 3'd5,
    CC_BAD6 = 3'd6,
    CC_BAD7 = 3'd7
  } case_e;

  typedef struct packed {
    logic disp;
    logic rearm;
    logic stall;
    logic in_en;
    logic in_cnak;
    logic out_en;
    logic out_cnak;
  } cmd_t;

  // weighted sum of the three OUT status bits
  function automatic case_e make_case(input logic xfer, input logic setup,
                                      input logic status);
    logic [2:0] sum;
    sum = {2'b00, xfer} + {1'b0, setup, 1'b0} + {status, 2'b00};
    return case_e'(sum);
  endfunction

  function automatic logic is_a_or_c(input case_e c);
    return (c == CC_A) || (c == CC_C);
  endfunction

  // modular advance of a buffer slot
  function automatic int unsigned next_slot(input int unsigned cur,
                                            input int unsigned count);
    return (cur + 1 >= count) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/ep0_case_decode.sv
module ep0_case_decode
  import ep0_seq_pkg::*;
(
  input  logic  xfer,
  input  logic  setup,
  input  logic  status,
  output case_e code,
  output logic  hit_ac,
  output logic  hit_b,
  output logic  hit_c
);
  always_comb begin
    code   = make_case(xfer, setup, status);
    hit_ac = is_a_or_c(code);
    hit_b  = (code == CC_B);
    hit_c  = (code == CC_C);
  end
endmodule

// File: rtl/ep0_pingpong.sv
module ep0_pingpong #(
  parameter int unsigned NUM_BUFS = 2,
  localparam int unsigned IDX_W = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_rst,
  input  logic             advance,
  output logic [IDX_W-1:0] cur_idx,
  output logic [IDX_W-1:0] nxt_idx
);
  import ep0_seq_pkg::*;

  logic [IDX_W-1:0] nxt_step;

  always_comb begin
    nxt_step = IDX_W'(next_slot(int'(nxt_idx), NUM_BUFS));
  end

  always_ff @(posedge clk) begin
    if (rst || bus_rst) begin
      cur_idx <= '0;
      nxt_idx <= '0;
    end else if (advance) begin
      cur_idx <= nxt_idx;
      nxt_idx <= nxt_step;
    end
  end
endmodule

// File: rtl/ep0_stage_fsm.sv
module ep0_stage_fsm
  import ep0_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   bus_rst,
  input  logic   out_irq,
  input  logic   in_irq,
  input  logic   in_xfer_done,
  input  logic   setup_flag,
  input  logic   hit_ac,
  input  logic   hit_b,
  input  logic   hit_c,
  input  logic   req_reject,
  input  logic   req_data_in,
  output stage_e stage_q,
  output cmd_t   cmd_q
);
  stage_e stage_d;
  cmd_t   cmd_d;
  logic   strobe;
  logic   in_done_ev;

  always_comb begin
    strobe     = out_irq || in_irq;
    in_done_ev = in_irq && in_xfer_done;
  end

  always_comb begin
    cmd_d   = '0;
    stage_d = stage_q;
    if (strobe) begin
      unique case (stage_q)
        STG_WAIT: begin
          if (hit_ac && setup_flag) begin
            cmd_d.disp = 1'b1;
          end else if (hit_ac) begin
            cmd_d.rearm = 1'b1;
          end else if (hit_b) begin
            cmd_d.stall = 1'b1;
          end
        end
        STG_DATA_IN: begin
          if (in_done_ev) cmd_d.in_en = 1'b1;
          if (out_irq) begin
            if (hit_b) begin
              cmd_d.in_en = 1'b1; cmd_d.in_cnak = 1'b1;
              cmd_d.out_en = 1'b1; cmd_d.out_cnak = 1'b1;
            end else if (hit_ac && setup_flag) begin
              cmd_d.disp = 1'b1;
            end else if (hit_ac) begin
              cmd_d.rearm = 1'b1;
            end
          end
        end
        STG_NO_DATA: begin
          if (in_done_ev) cmd_d.in_en = 1'b1;
          if (out_irq) begin
            if (hit_b) begin
              cmd_d.in_en = 1'b1; cmd_d.in_cnak = 1'b1;
              cmd_d.out_en = 1'b1; cmd_d.out_cnak = 1'b1;
            end else if (hit_ac && setup_flag) begin
              cmd_d.disp = 1'b1;
            end else begin
              cmd_d.rearm = 1'b1;
            end
          end
        end
        default: stage_d = STG_WAIT;
      endcase

      // outcome of a re-arm
      if (cmd_d.rearm) begin
        cmd_d.out_en   = 1'b1;
        cmd_d.out_cnak = 1'b1;
        stage_d        = STG_WAIT;
      end
      // outcome of a SETUP hand-over
      if (cmd_d.disp) begin
        if (req_reject) begin
          cmd_d.stall = 1'b1;
          stage_d     = STG_WAIT;
        end else begin
          cmd_d.in_en    = 1'b1;
          cmd_d.out_en   = 1'b1;
          cmd_d.in_cnak  = hit_c;
          cmd_d.out_cnak = hit_c;
          stage_d        = req_data_in ? STG_DATA_IN : STG_NO_DATA;
        end
      end
      if (cmd_d.stall) stage_d = STG_WAIT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || bus_rst) begin
      stage_q <= STG_WAIT;
      cmd_q   <= '0;
    end else begin
      stage_q <= stage_d;
      cmd_q   <= cmd_d;
    end
  end
endmodule

// File: rtl/ep0_stage_seq.sv
module ep0_stage_seq #(
  parameter int unsigned NUM_BUFS = 2,
  localparam int unsigned IDX_W = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_rst,
  input  logic             out_irq,
  input  logic             in_irq,
  input  logic             out_xfer_done,
  input  logic             out_setup_done,
  input  logic             out_status_rcvd,
  input  logic             setup_flag,
  input  logic             in_xfer_done,
  input  logic             req_reject,
  input  logic             req_data_in,
  output logic [1:0]       stage,
  output logic [IDX_W-1:0] cur_idx,
  output logic [IDX_W-1:0] nxt_idx,
  output logic             dispatch,
  output logic             rearm,
  output logic             stall_both,
  output logic             in_en,
  output logic             in_cnak,
  output logic             out_en,
  output logic             out_cnak
);
  import ep0_seq_pkg::*;

  case_e  code;
  logic   hit_ac, hit_b, hit_c;
  logic   rx_advance;
  stage_e stage_q;
  cmd_t   cmd_q;

  always_comb rx_advance = out_irq && out_xfer_done;

  ep0_case_decode u_decode (
    .xfer   (out_xfer_done),
    .setup  (out_setup_done),
    .status (out_status_rcvd),
    .code   (code),
    .hit_ac (hit_ac),
    .hit_b  (hit_b),
    .hit_c  (hit_c)
  );

  ep0_pingpong #(.NUM_BUFS(NUM_BUFS)) u_pingpong (
    .clk     (clk),
    .rst     (rst),
    .bus_rst (bus_rst),
    .advance (rx_advance),
    .cur_idx (cur_idx),
    .nxt_idx (nxt_idx)
  );

  ep0_stage_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .bus_rst      (bus_rst),
    .out_irq      (out_irq),
    .in_irq       (in_irq),
    .in_xfer_done (in_xfer_done),
    .setup_flag   (setup_flag),
    .hit_ac       (hit_ac),
    .hit_b        (hit_b),
    .hit_c        (hit_c),
    .req_reject   (req_reject),
    .req_data_in  (req_data_in),
    .stage_q      (stage_q),
    .cmd_q        (cmd_q)
  );

  always_comb begin
    stage      = stage_q;
    dispatch   = cmd_q.disp;
    rearm      = cmd_q.rearm;
    stall_both = cmd_q.stall;
    in_en      = cmd_q.in_en;
    in_cnak    = cmd_q.in_cnak;
    out_en     = cmd_q.out_en;
    out_cnak   = cmd_q.out_cnak;
  end
endmodule

// File: rtl/ep0_stage_seq_chk.sv
module ep0_stage_seq_chk #(
  parameter int unsigned IDX_W = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_rst,
  input logic             out_irq,
  input logic             in_irq,
  input logic             out_xfer_done,
  input logic             out_setup_done,
  input logic             out_status_rcvd,
  input logic             setup_flag,
  input logic [1:0]       stage,
  input logic [IDX_W-1:0] cur_idx,
  input logic [IDX_W-1:0] nxt_idx,
  input logic             dispatch,
  input logic             rearm,
  input logic             stall_both,
  input logic             in_en,
  input logic             in_cnak,
  input logic             out_en,
  input logic             out_cnak
);
  AST_QUIET_NO_CMD: assert property (@(posedge clk) disable iff (rst || bus_rst)
    !(out_irq || in_irq) |=> !(dispatch || rearm || stall_both || in_en || in_cnak || out_en || out_cnak)); // R12
  AST_DISPATCH_FLAG: assert property (@(posedge clk) disable iff (rst || bus_rst)
    dispatch |-> ($past(setup_flag) && $past(out_irq || in_irq))); // R2
  AST_STALL_WAIT: assert property (@(posedge clk) disable iff (rst || bus_rst)
    stall_both |-> (stage == 2'd0)); // R4
  AST_REARM_WAIT: assert property (@(posedge clk) disable iff (rst || bus_rst)
    rearm |-> (stage == 2'd0) && out_en && out_cnak); // R3
  AST_REARM_STALL_EXCL: assert property (@(posedge clk) disable iff (rst || bus_rst)
    $onehot0({rearm, stall_both})); // R5
  AST_CNAK_CASE_C: assert property (@(posedge clk) disable iff (rst || bus_rst)
    (dispatch && !stall_both) |->
      (in_cnak == $past(out_xfer_done && out_setup_done && !out_status_rcvd))); // R5
  AST_DATAIN_NO_OUT: assert property (@(posedge clk) disable iff (rst || bus_rst)
    (stage == 2'd1 && !out_irq) |=> !(dispatch || rearm || out_en)); // R6
  AST_PP_SWAP: assert property (@(posedge clk) disable iff (rst || bus_rst)
    (out_irq && out_xfer_done) |=> (cur_idx == $past(nxt_idx))); // R10
  AST_PP_HOLD: assert property (@(posedge clk) disable iff (rst || bus_rst)
    !(out_irq && out_xfer_done) |=> ($stable(nxt_idx) && $stable(cur_idx))); // R10
  AST_RESET_IDLE: assert property (@(posedge clk)
    (rst || bus_rst) |=> (stage == 2'd0 && nxt_idx == '0 && !dispatch && !stall_both)); // R11
endmodule

bind ep0_stage_seq ep0_stage_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .bus_rst(bus_rst), .out_irq(out_irq), .in_irq(in_irq),
  .out_xfer_done(out_xfer_done), .out_setup_done(out_setup_done),
  .out_status_rcvd(out_status_rcvd), .setup_flag(setup_flag), .stage(stage),
  .cur_idx(cur_idx), .nxt_idx(nxt_idx), .dispatch(dispatch), .rearm(rearm),
  .stall_both(stall_both), .in_en(in_en), .in_cnak(in_cnak), .out_en(out_en),
  .out_cnak(out_cnak)
);

// File: tb/test_ep0_stage_seq.sv
`timescale 1ns/1ps
module test_ep0_stage_seq;
  logic clk = 1'b0;
  logic rst, bus_rst, out_irq, in_irq, out_xfer_done, out_setup_done, out_status_rcvd;
  logic setup_flag, in_xfer_done, req_reject, req_data_in;
  logic [1:0] stage;
  logic [0:0] cur_idx, nxt_idx;
  logic dispatch, rearm, stall_both, in_en, in_cnak, out_en, out_cnak;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;
  int  e_cur = 0;
  int  e_nxt = 0;

  always #2.5 clk = ~clk;

  ep0_stage_seq i_ep0_stage_seq (
    .clk(clk), .rst(rst), .bus_rst(bus_rst), .out_irq(out_irq), .in_irq(in_irq),
    .out_xfer_done(out_xfer_done), .out_setup_done(out_setup_done),
    .out_status_rcvd(out_status_rcvd), .setup_flag(setup_flag),
    .in_xfer_done(in_xfer_done), .req_reject(req_reject), .req_data_in(req_data_in),
    .stage(stage), .cur_idx(cur_idx), .nxt_idx(nxt_idx), .dispatch(dispatch),
    .rearm(rearm), .stall_both(stall_both), .in_en(in_en), .in_cnak(in_cnak),
    .out_en(out_en), .out_cnak(out_cnak)
  );

  function automatic logic [6:0] cmds_now();
    return {dispatch, rearm, stall_both, in_en, in_cnak, out_en, out_cnak};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic quiet();
    out_irq = 0; in_irq = 0; out_xfer_done = 0; out_setup_done = 0;
    out_status_rcvd = 0; setup_flag = 0; in_xfer_done = 0;
    req_reject = 0; req_data_in = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; quiet();
    @(negedge clk); rst = 0;
    e_cur = 0; e_nxt = 0;
  endtask

  // one-cycle strobe; returns at the falling edge after the capturing rising edge
  task automatic strobe(input bit oi, input bit ii, input logic [2:0] code,
                        input bit f, input bit ix, input bit rej, input bit din);
    @(negedge clk);
    out_irq = oi; in_irq = ii;
    out_xfer_done = code[0]; out_setup_done = code[1]; out_status_rcvd = code[2];
    setup_flag = f; in_xfer_done = ix; req_reject = rej; req_data_in = din;
    @(negedge clk);
    quiet();
    if (oi && code[0]) begin e_cur = e_nxt; e_nxt = 1 - e_nxt; end
  endtask

  // expected {next stage, commands} from the requirement text
  function automatic logic [8:0] predict(input int st, input int code, input bit f,
      input bit oi, input bit ii, input bit ix, input bit rej, input bit din);
    int  act;      // 0 none 1 hand-over 2 re-arm 3 stall 4 all enables
    bit  caseac, caseb, casec;
    logic [6:0] c;
    int  ns;
    caseac = (code == 1) || (code == 3);
    caseb  = (code == 2);
    casec  = (code == 3);
    act = 0;
    if (st == 0) begin
      if (oi || ii) act = caseac ? (f ? 1 : 2) : (caseb ? 3 : 0);
    end else if (st == 1) begin
      if (oi) act = caseb ? 4 : (caseac ? (f ? 1 : 2) : 0);
    end else begin
      if (oi) act = caseb ? 4 : ((caseac && f) ? 1 : 2);
    end
    c = '0; ns = st;
    case (act)
      1: begin
        c[6] = 1;
        if (rej) begin c[4] = 1; ns = 0; end
        else begin c[3] = 1; c[1] = 1; c[2] = casec; c[0] = casec; ns = din ? 1 : 2; end
      end
      2: begin c[5] = 1; c[1] = 1; c[0] = 1; ns = 0; end
      3: begin c[4] = 1; ns = 0; end
      4: c[3:0] = 4'b1111;
      default: ;
    endcase
    if (st != 0 && ii && ix) c[3] = 1;
    return {ns[1:0], c};
  endfunction

  function automatic string tag_of(input int st, input int code, input bit f,
                                   input bit oi, input bit rej);
    bit caseac = (code == 1) || (code == 3);
    if (st == 0) begin
      if (caseac && f) return rej ? "R5" : "R2";
      if (caseac) return "R3";
      if (code == 2) return "R4";
      return "R1";
    end
    if (st == 1) begin
      if (!oi) return "R6";
      return (code == 2) ? "R7" : "R8";
    end
    return "R9";
  endfunction

  initial begin
    logic [8:0] exp;
    rst = 1; bus_rst = 0; quiet();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R11", "reset stage", 32'(stage), 0);
    check("R11", "reset commands", 32'(cmds_now()), 0);
    check("R11", "reset indices", 32'({cur_idx, nxt_idx}), 0);

    for (int st = 0; st < 3; st++)
      for (int code = 0; code < 8; code++)
        for (int v = 0; v < 32; v++) begin
          bit f, oi, ii, ix, rej, din;
          {f, oi, ii, ix, rej} = v[4:0];
          for (int d = 0; d < 2; d++) begin
            din = d[0];
            do_reset();
            if (st != 0) strobe(1, 0, 3'd1, 1, 0, 0, st == 1);
            strobe(oi, ii, 3'(code), f, ix, rej, din);
            exp = predict(st, code, f, oi, ii, ix, rej, din);
            check(tag_of(st, code, f, oi, rej), "commands", 32'(cmds_now()), 32'(exp[6:0]));
            check(tag_of(st, code, f, oi, rej), "stage", 32'(stage), 32'(exp[8:7]));
            check("R10", "indices", 32'({cur_idx, nxt_idx}), 32'({e_cur[0], e_nxt[0]}));
            @(negedge clk);
            check("R12", "pulse width", 32'(cmds_now()), 0);
          end
        end

    // R5 clear-NAK only for case C on accepted hand-over
    do_reset();
    strobe(1, 0, 3'd3, 1, 0, 0, 1);
    check("R5", "case C cnak", 32'({in_cnak, out_cnak, in_en, out_en}), 32'hF);
    check("R5", "case C stage", 32'(stage), 1);
    do_reset();
    strobe(1, 0, 3'd1, 1, 0, 0, 0);
    check("R5", "case A cnak", 32'({in_cnak, out_cnak, in_en, out_en}), 32'h3);
    check("R5", "case A stage", 32'(stage), 2);

    // R10 three consecutive receptions alternate indices
    do_reset();
    for (int k = 0; k < 3; k++) begin
      strobe(1, 0, 3'd1, 0, 0, 0, 0);
      check("R10", "rotation", 32'({cur_idx, nxt_idx}), 32'({e_cur[0], e_nxt[0]}));
    end

    // R11 bus reset beats a simultaneous strobe
    do_reset();
    strobe(1, 0, 3'd1, 1, 0, 0, 1);
    @(negedge clk);
    bus_rst = 1; out_irq = 1; out_setup_done = 1;
    @(negedge clk);
    bus_rst = 0; quiet();
    check("R11", "bus reset stage", 32'(stage), 0);
    check("R11", "bus reset commands", 32'(cmds_now()), 0);
    check("R11", "bus reset indices", 32'({cur_idx, nxt_idx}), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R12 watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule